// File: doc/BRIEF.md
# DRAM Refresh Burst Sequencer

This block runs DRAM refresh cycles on behalf of an outside agent. The agent may fire a single refresh with a one-clock low pulse on `refresh_req_n`, or it may hold that input low to chain refreshes one after another. The block holds a request in a latch until the memory is free, which means no access is running and the precharge after the last access has elapsed. It then drops `ras_n` for the programmed number of clock periods and restores it for the programmed precharge gap. It advances a row counter each time a refresh RAS ends.

Requests are honoured only while `ext_refresh_en` is high. That input is the mode in which the controller's own timed refreshes are switched off. The row counter is 11 bits wide. Its upper bits rise after 128, 256, 512 and 1024 completed refreshes. Read together with `refresh_active`, they show when a whole-array burst has finished.

Top module: `dram_burst_refresh`

## Requirements
- R1: While `ext_refresh_en` is low, a low level on `refresh_req_n` is not latched and starts no refresh: `ras_n` stays 1 and `row_count` does not change.
- R2: A request needs to be low at one rising clock edge only. If the memory is free at that edge, `ras_n` goes low at that same edge. Otherwise the request stays latched until the memory is free.
- R3: Every refresh holds `ras_n` low for exactly `ras_low_sel`+2 clock periods (encoding 0..3 gives 2..5).
- R4: No refresh starts at an edge where `access_busy` is sampled high. After the last edge at which `access_busy` was high, `ras_pre_sel`+2 further edges must pass before a refresh can start.
- R5: If `refresh_req_n` is low at the edge that ends a refresh RAS, another refresh follows after the precharge gap. If it is high there and no new request arrives during the precharge, the sequence stops.
- R6: Between two refreshes of a burst, `ras_n` stays high for exactly `ras_pre_sel`+2 clock periods (encoding 0..3 gives 2..5).
- R7: The request latch is cleared at the edge where the final refresh RAS rises. A request pulse that falls wholly inside a RAS-low period, before its ending edge, adds no refresh.
- R8: `refresh_active` goes high at the edge that drops `ras_n`. It stays high through the precharge that follows the final refresh of a sequence, and goes low at the edge where that precharge completes.
- R9: `row_count` rises by one, modulo 2048, at each edge where a refresh `ras_n` rises, and changes at no other time. Bits 7, 8, 9 and 10 are first set after 128, 256, 512 and 1024 refreshes.
- R10: When `rst` is high at a rising edge, the block clears the latch, the counter and the sequence, and drives `ras_n`=1 and `refresh_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_refresh_en | input | 1 | High selects externally requested refresh (internal refresh disabled) |
| refresh_req_n | input | 1 | Active-low refresh request; pulse or hold |
| access_busy | input | 1 | High while a normal read or write access is in progress |
| ras_low_sel | input | 2 | RAS-low length code, length = code+2 periods |
| ras_pre_sel | input | 2 | RAS precharge length code, length = code+2 periods |
| ras_n | output | 1 | Active-low row strobe for refresh |
| refresh_active | output | 1 | High while a refresh sequence is in progress |
| row_count | output | 11 | Refresh row counter; bits 7..10 are progress decodes |

## Verification
The block is driven with several patterns. Single one-clock pulses separate the latch behaviour from level sensing. A pulse issued while `access_busy` is high, and then busy released, shows whether the block waits out the access precharge. A request held low across several ending edges shows whether bursts chain and how long the precharge between them lasts. A pulse placed inside a RAS-low period shows whether the latch clears when RAS rises. An uninterrupted 2048-refresh burst walks the counter through every progress bit and back to zero, and a behavioural model compares the strobe, the active flag and the counter on every clock.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_PRE  = 2'd2
    } rfb_state_e;

    localparam int unsigned LEN_BIAS = 2;

endpackage

// File: rtl/rfb_gap_timer.sv
module rfb_gap_timer #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned TMR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             access_busy,
    input  logic [TMR_W-1:0] pre_len,
    output logic             mem_free
);

    logic [TMR_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (access_busy) begin
            gap_d = pre_len;
        end else if (gap_q != '0) begin
            gap_d = gap_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gap_q <= '0;
        else     gap_q <= gap_d;
    end

    assign mem_free = !access_busy && (gap_q == '0);

    // R4: right after busy is sampled, the gap counter holds a full precharge
    p_gap_loaded_r4: assert property (@(posedge clk) disable iff (rst)
        $past(access_busy) |-> (gap_q == $past(pre_len)));

    logic unused_sel;
    assign unused_sel = (SEL_W == 0);

endmodule

// File: rtl/rfb_row_counter.sv
module rfb_row_counter #(
    parameter int unsigned ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [ROW_W-1:0] count
);

    logic [ROW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = cnt_q + ROW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R9: counter moves only when stepped, by exactly one
    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(step) |-> $stable(cnt_q));

endmodule

// File: rtl/dram_burst_refresh.sv
module dram_burst_refresh #(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_refresh_en,
    input  logic             refresh_req_n,
    input  logic             access_busy,
    input  logic [SEL_W-1:0] ras_low_sel,
    input  logic [SEL_W-1:0] ras_pre_sel,
    output logic             ras_n,
    output logic             refresh_active,
    output logic [ROW_W-1:0] row_count
);
    import rfb_pkg::*;

    localparam int unsigned MAX_LEN = (1 << SEL_W) - 1 + LEN_BIAS;
    localparam int unsigned TMR_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        rfb_state_e       st;
        logic             ras_n;
        logic             act;
        logic             req;
        logic [TMR_W-1:0] tmr;
    } seq_t;

    seq_t             s_d, s_q;
    logic [TMR_W-1:0] low_len, pre_len;
    logic             req_now, pending, mem_free, step;

    assign low_len = TMR_W'(ras_low_sel) + TMR_W'(LEN_BIAS);
    assign pre_len = TMR_W'(ras_pre_sel) + TMR_W'(LEN_BIAS);
    assign req_now = ext_refresh_en && !refresh_req_n;
    assign pending = s_q.req || req_now;

    rfb_gap_timer #(.SEL_W(SEL_W), .TMR_W(TMR_W)) u_gap (
        .clk         (clk),
        .rst         (rst),
        .access_busy (access_busy),
        .pre_len     (pre_len),
        .mem_free    (mem_free)
    );

    always_comb begin
        s_d  = s_q;
        step = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.req = pending;
                if (pending && mem_free) begin
                    s_d.st    = ST_LOW;
                    s_d.ras_n = 1'b0;
                    s_d.act   = 1'b1;
                    s_d.tmr   = low_len - TMR_W'(1);
                end
            end
            ST_LOW: begin
                if (s_q.tmr == '0) begin
                    step      = 1'b1;
                    s_d.st    = ST_PRE;
                    s_d.ras_n = 1'b1;
                    s_d.tmr   = pre_len - TMR_W'(1);
                    s_d.req   = req_now;
                end else begin
                    s_d.tmr = s_q.tmr - TMR_W'(1);
                    s_d.req = pending;
                end
            end
            ST_PRE: begin
                s_d.req = pending;
                if (s_q.tmr != '0) begin
                    s_d.tmr = s_q.tmr - TMR_W'(1);
                end else if (pending && mem_free) begin
                    s_d.st    = ST_LOW;
                    s_d.ras_n = 1'b0;
                    s_d.tmr   = low_len - TMR_W'(1);
                end else begin
                    s_d.st  = ST_IDLE;
                    s_d.act = 1'b0;
                end
            end
            default: begin
                s_d.st    = ST_IDLE;
                s_d.ras_n = 1'b1;
                s_d.act   = 1'b0;
                s_d.req   = 1'b0;
                s_d.tmr   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st    <= ST_IDLE;
            s_q.ras_n <= 1'b1;
            s_q.act   <= 1'b0;
            s_q.req   <= 1'b0;
            s_q.tmr   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rfb_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .count (row_count)
    );

    assign ras_n          = s_q.ras_n;
    assign refresh_active = s_q.act;

    // run-length trackers for timing checks
    logic [TMR_W:0] low_run_q, high_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q  <= '0;
            high_run_q <= '0;
        end else begin
            low_run_q  <= ras_n ? '0 : low_run_q + 1'b1;
            if (!ras_n)                       high_run_q <= '0;
            else if (high_run_q != '1)        high_run_q <= high_run_q + 1'b1;
        end
    end

    p_strobe_in_seq_r8: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> refresh_active);

    p_low_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run_q == {1'b0, low_len}));

    p_pre_len_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && $past(refresh_active)) |-> (high_run_q == {1'b0, pre_len}));

    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (row_count == $past(row_count) + ROW_W'(1)));

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> !$past(access_busy));

    p_start_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !$past(refresh_active)) |->
            $past(s_q.req || (ext_refresh_en && !refresh_req_n)));

endmodule

// File: tb/dram_burst_refresh_bench.sv
module dram_burst_refresh_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_en = 1'b0;
    logic        req_n = 1'b1;
    logic        busy = 1'b0;
    logic [1:0]  low_sel = 2'd0;
    logic [1:0]  pre_sel = 2'd0;
    logic        ras_n, act;
    logic [10:0] rows;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    dram_burst_refresh u_dram_burst_refresh (
        .clk            (clk),
        .rst            (rst),
        .ext_refresh_en (ext_en),
        .refresh_req_n  (req_n),
        .access_busy    (busy),
        .ras_low_sel    (low_sel),
        .ras_pre_sel    (pre_sel),
        .ras_n          (ras_n),
        .refresh_active (act),
        .row_count      (rows)
    );

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 strobe low, 2 precharge
    int m_phase = 0, m_left = 0, m_gap = 0, m_cnt = 0;
    bit m_latch = 0, m_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_left = 0; m_gap = 0; m_cnt = 0; m_latch = 0; m_valid = 1;
        end else begin
            bit want, free, held;
            held = ext_en && !req_n;
            want = m_latch || held;
            free = !busy && (m_gap == 0);
            if (m_phase == 0) begin
                m_latch = want;
                if (want && free) begin m_phase = 1; m_left = low_sel + 2; end
            end else if (m_phase == 1) begin
                m_left--;
                m_latch = want;
                if (m_left == 0) begin
                    m_phase = 2; m_left = pre_sel + 2;
                    m_cnt = (m_cnt + 1) % 2048;
                    m_latch = held;
                end
            end else begin
                m_left--;
                m_latch = want;
                if (m_left == 0) begin
                    if (want && free) begin m_phase = 1; m_left = low_sel + 2; end
                    else m_phase = 0;
                end
            end
            if (busy) m_gap = pre_sel + 2;
            else if (m_gap > 0) m_gap--;
        end
    end

    // every-clock comparison and run-length monitor
    int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
    logic prev_ras = 1'b1;
    always @(negedge clk) begin
        if (m_valid && !rst && !done) begin
            chk(ras_n == (m_phase != 1), "R3/R6 ras_n vs model", ras_n, m_phase != 1);
            chk(act == (m_phase != 0), "R8 refresh_active vs model", act, m_phase != 0);
            chk(rows == m_cnt, "R9 row_count vs model", rows, m_cnt);
        end
        if (!ras_n && prev_ras) last_hi = hi_run;
        if (ras_n && !prev_ras) last_lo = lo_run;
        if (ras_n) begin hi_run = prev_ras ? hi_run + 1 : 1; lo_run = 0; end
        else       begin lo_run = prev_ras ? 1 : lo_run + 1; hi_run = 0; end
        prev_ras = ras_n;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk) req_n = 1'b0;
        @(negedge clk) req_n = 1'b1;
    endtask

    initial begin
        int base, n;
        bit saw_low;
        cyc(3);
        // R10 reset state
        chk(ras_n === 1'b1, "R10 ras_n after reset", ras_n, 1);
        chk(act === 1'b0, "R10 active after reset", act, 0);
        chk(rows === 11'd0, "R10 count after reset", rows, 0);
        @(negedge clk) rst = 1'b0;

        // R1 request ignored with external mode off
        pulse();
        saw_low = 0;
        repeat (12) begin @(negedge clk); if (!ras_n) saw_low = 1; end
        chk(!saw_low, "R1 no strobe with mode off", saw_low, 0);
        chk(rows == 0, "R1 count unchanged with mode off", rows, 0);

        // R2 single pulse starts at the sampling edge; R3 five-period low
        ext_en = 1'b1; low_sel = 2'd3; pre_sel = 2'd0;
        @(negedge clk) req_n = 1'b0;
        @(negedge clk) req_n = 1'b1;
        chk(ras_n == 1'b0, "R2 strobe low after pulse edge", ras_n, 0);
        cyc(12);
        chk(last_lo == 5, "R3 low length code 3", last_lo, 5);
        chk(rows == 1, "R2 single pulse one refresh", rows, 1);
        // R8 active falls after precharge
        chk(act == 1'b0, "R8 active low after sequence", act, 0);

        // R4 hold-off while busy, then precharge gap
        pre_sel = 2'd1; low_sel = 2'd0;
        @(negedge clk) busy = 1'b1;
        pulse();
        cyc(8);
        chk(ras_n == 1'b1, "R4 no strobe while busy", ras_n, 1);
        @(negedge clk) busy = 1'b0;
        n = 0;
        while (ras_n && n < 20) begin @(negedge clk); n++; end
        chk(n == 4, "R4 start delay after busy", n, 4);
        cyc(12);

        // R5/R6 burst chaining with four-period precharge
        low_sel = 2'd0; pre_sel = 2'd2;
        base = rows;
        @(negedge clk) req_n = 1'b0;
        while (rows != base + 3) @(negedge clk);
        req_n = 1'b1;
        cyc(30);
        chk(rows == base + 4, "R5 burst count", rows, base + 4);
        chk(last_hi == 4, "R6 precharge between refreshes", last_hi, 4);
        chk(last_lo == 2, "R3 low length code 0", last_lo, 2);

        // R7 pulse inside strobe-low period is dropped
        low_sel = 2'd3; pre_sel = 2'd0;
        base = rows;
        pulse();
        cyc(1);
        pulse();
        cyc(20);
        chk(rows == base + 1, "R7 mid-strobe pulse adds nothing", rows, base + 1);

        // R9 full-array burst with progress bits and wrap
        @(negedge clk) rst = 1'b1;
        cyc(2);
        chk(rows == 0, "R10 count cleared by reset", rows, 0);
        rst = 1'b0; low_sel = 2'd0; pre_sel = 2'd0;
        @(negedge clk) req_n = 1'b0;
        while (rows != 128) @(negedge clk);
        chk(rows[7] && rows[6:0] == 0, "R9 bit 7 after 128", rows, 128);
        while (rows != 1024) @(negedge clk);
        chk(rows[10] && rows[9:0] == 0, "R9 bit 10 after 1024", rows, 1024);
        while (rows != 2047) @(negedge clk);
        req_n = 1'b1;
        cyc(20);
        chk(rows == 0, "R9 wrap to zero after 2048", rows, 0);
        chk(act == 1'b0, "R8 burst finished", act, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule